// File: doc/BRIEF.md
# SPI NOR Page-Program Write Sequencer

This block takes a write request (start address, byte count) plus a byte stream and turns it into a series of page-program commands on a serial NOR flash. It never lets one program command run past a programming-page boundary. The chunk size is based on an effective page size. That size is the smaller of the device page size, given per request as a power of two, and a build-time maximum write size.

Before each chunk the sequencer polls the flash status register until the busy flag clears. The wait between status reads is fixed, and the whole wait has a deadline. Next it sends write-enable and reads the status back to confirm the latch is set. Only then does it send the program opcode, the address and the data. Once the last chunk has gone out, the sequencer waits for busy to clear one more time and then signals completion. Any failure ends the request at once and raises an error pulse with a cause code.

The user side has a request handshake and a byte handshake. The flash side is a mode-0 SPI master, driven by an internal byte shifter that takes two clock cycles per bit.

Top module: `nor_page_writer`

## Requirements
- R1: The effective page size is 2^min(devPageLog2, MAX_WR_LOG2) bytes. devPageLog2 is sampled when the request is accepted.
- R2: Each program command carries min(remaining, pageSize - (addr & (pageSize-1))) bytes. No command crosses a page boundary.
- R3: Before every chunk, and before completion, the sequencer frames a status read: opcode 0x05, then one byte clocked in. It repeats the read until status bit 0 (busy) is 0.
- R4: While busy stays set, status reads are spaced POLL_GAP_CYC cycles apart. If TIMEOUT_CYC cycles have passed since the wait began, the request ends with errO and errCode 2'b01.
- R5: Each chunk is preceded by its own frame holding opcode 0x06, followed by a status read. If status bit 1 (write-enable latch) is 0, the request ends with errO and errCode 2'b10, and no program command is sent.
- R6: A program frame is opcode 0x02, then the address most significant byte first, then the data bytes. The address is 4 bytes when fourByteMode was 1 at acceptance and the low 3 bytes otherwise.
- R7: After the last chunk, the flash is no longer busy when doneO pulses.
- R8: A request with length 0 performs exactly one status read and then pulses doneO.
- R9: After doneO or errO, chip select is high and reqReady is 1 on the next cycle.
- R10: Each streamed byte is taken exactly once (dataReady with dataValid) and lands at consecutive flash addresses in stream order.
- R11: During and after reset, spiCsN is 1, spiSclk is 0, reqReady is 1, and doneO and errO are 0. SCLK idles low between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Sequencer idle, request taken when valid |
| reqAddr | input | 32 | Start flash address |
| reqLen | input | LEN_W | Byte count |
| fourByteMode | input | 1 | 1: send 4 address bytes, 0: send 3 |
| devPageLog2 | input | 4 | log2 of device programming page size |
| dataValid | input | 1 | Stream byte present |
| dataReady | output | 1 | Stream byte consumed this cycle |
| dataByte | input | 8 | Stream byte |
| doneO | output | 1 | One-cycle pulse, request finished |
| errO | output | 1 | One-cycle pulse, request aborted |
| errCode | output | 2 | 01 busy timeout, 10 latch not set |
| spiSclk | output | 1 | SPI clock, mode 0 |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data out |
| spiMiso | input | 1 | SPI data in |

## Verification
The bench models a flash that records every program frame and can stay busy for a set number of status reads. It compares each recorded chunk against an independently computed split. The directed cases are:
- Writes that straddle a page edge. A sequencer that ignored alignment would emit a frame crossing the edge.
- Device pages larger and smaller than the write limit. Taking the wrong minimum changes the chunk count.
- A high address in 4-byte mode. A wrong address width garbles the recorded address.
- A busy that never ends. A missing deadline hangs.
- A latch that never sets. Skipping the check would program anyway.
- A zero-length request. The status read count exposes a missing or doubled final wait.

// File: rtl/nor_pw_pkg.sv
package nor_pw_pkg;
  localparam int ADDR_W = 32;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    TX_WREN, TX_RDSR, TX_PROG, TX_DUMMY, TX_ADDR, TX_DATA
  } txSel_e;

  typedef struct packed {
    logic   loadReq;
    logic   loadChunk;
    logic   clrTimer;
    logic   clrGap;
    logic   csLow;
    logic   csHigh;
    logic   addrStep;
    logic   dataStep;
    logic   capStatus;
    txSel_e txSel;
  } ctlStrobe_t;
endpackage

// File: rtl/nor_pw_shift.sv
module nor_pw_shift (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] txByte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rxByte,
  output logic       sclk,
  output logic       mosi
);
  logic [7:0] txSh;
  logic [2:0] bitCnt;
  logic       phase;

  assign mosi = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; rxByte <= '0; sclk <= 1'b0;
      txSh <= '0; bitCnt <= '0; phase <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; txSh <= txByte; bitCnt <= 3'd7; phase <= 1'b0; sclk <= 1'b0;
      end else if (busy) begin
        if (!phase) begin
          sclk   <= 1'b1;
          rxByte <= {rxByte[6:0], miso};
          phase  <= 1'b1;
        end else begin
          sclk   <= 1'b0;
          phase  <= 1'b0;
          txSh   <= {txSh[6:0], 1'b0};
          bitCnt <= bitCnt - 3'd1;
          if (bitCnt == 3'd0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk); // R11
endmodule

// File: rtl/nor_pw_dp.sv
module nor_pw_dp
  import nor_pw_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int MAX_WR_LOG2  = 8,
  parameter int POLL_GAP_CYC = 500,
  parameter int TIMEOUT_CYC  = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              fourByteMode,
  input  logic [3:0]        devPageLog2,
  input  logic [7:0]        dataByte,
  input  logic [1:0]        rxStat,
  output logic [7:0]        txByte,
  output logic              csN,
  output logic              wip,
  output logic              wel,
  output logic              addrLast,
  output logic              chunkEmpty,
  output logic              remZero,
  output logic              gapDone,
  output logic              tmoHit
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W = $clog2(POLL_GAP_CYC + 1);
  localparam logic [3:0] MAX_L2 = 4'(MAX_WR_LOG2);

  logic [ADDR_W-1:0] curAddr, chunkAddr;
  logic [LEN_W-1:0]  remLen, chunkLeft, chunkNext;
  logic [3:0]        pageLog2Q, effLog2;
  logic              fourB;
  logic [1:0]        addrIdx, statusQ;
  logic [TMO_W-1:0]  tmoCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [LEN_W:0]    effPage, pageMask, room;

  assign effLog2  = (pageLog2Q < MAX_L2) ? pageLog2Q : MAX_L2;
  assign effPage  = (LEN_W+1)'(1) << effLog2;
  assign pageMask = effPage - (LEN_W+1)'(1);
  assign room     = effPage - ({1'b0, curAddr[LEN_W-1:0]} & pageMask);
  assign chunkNext = ({1'b0, remLen} < room) ? remLen : room[LEN_W-1:0];

  assign wip        = statusQ[0];
  assign wel        = statusQ[1];
  assign addrLast   = (addrIdx == 2'd0);
  assign chunkEmpty = (chunkLeft == '0);
  assign remZero    = (remLen == '0);
  assign tmoHit     = (tmoCnt >= TMO_W'(TIMEOUT_CYC));
  assign gapDone    = (gapCnt == GAP_W'(POLL_GAP_CYC));

  always_comb begin
    unique case (ctl.txSel)
      TX_WREN: txByte = OP_WREN;
      TX_RDSR: txByte = OP_RDSR;
      TX_PROG: txByte = OP_PROG;
      TX_ADDR: txByte = chunkAddr[{addrIdx, 3'b000} +: 8];
      TX_DATA: txByte = dataByte;
      default: txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0; chunkAddr <= '0; remLen <= '0; chunkLeft <= '0;
      pageLog2Q <= '0; fourB <= 1'b0; addrIdx <= '0; statusQ <= '0;
      tmoCnt <= '0; gapCnt <= '0; csN <= 1'b1;
    end else begin
      if (ctl.loadReq) begin
        curAddr <= reqAddr; remLen <= reqLen;
        pageLog2Q <= devPageLog2; fourB <= fourByteMode;
      end
      if (ctl.loadChunk) begin
        chunkAddr <= curAddr;
        chunkLeft <= chunkNext;
        addrIdx   <= fourB ? 2'd3 : 2'd2;
      end
      if (ctl.addrStep) addrIdx <= addrIdx - 2'd1;
      if (ctl.dataStep) begin
        curAddr   <= curAddr + ADDR_W'(1);
        remLen    <= remLen - LEN_W'(1);
        chunkLeft <= chunkLeft - LEN_W'(1);
      end
      if (ctl.capStatus) statusQ <= rxStat;
      if (ctl.clrTimer) tmoCnt <= '0;
      else if (!tmoHit) tmoCnt <= tmoCnt + TMO_W'(1);
      if (ctl.clrGap) gapCnt <= '0;
      else if (!gapDone) gapCnt <= gapCnt + GAP_W'(1);
      if (ctl.csHigh) csN <= 1'b1;
      else if (ctl.csLow) csN <= 1'b0;
    end
  end

  AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadChunk |=> (chunkLeft != '0) &&
      ((({1'b0, chunkAddr[LEN_W-1:0]} & pageMask) + {1'b0, chunkLeft}) <= effPage)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataStep |-> (remLen != '0) && (chunkLeft != '0)); // R10
endmodule

// File: rtl/nor_pw_ctl.sv
module nor_pw_ctl
  import nor_pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       dataValid,
  input  logic       shDone,
  input  logic       wip,
  input  logic       wel,
  input  logic       addrLast,
  input  logic       chunkEmpty,
  input  logic       remZero,
  input  logic       gapDone,
  input  logic       tmoHit,
  output ctlStrobe_t ctl,
  output logic       shStart,
  output logic       reqReady,
  output logic       dataReady,
  output logic       doneO,
  output logic       errO,
  output logic [1:0] errCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_POLL_EVAL, S_POLL_WAIT,
    S_WREN, S_LAT_OP, S_LAT_RD, S_LAT_EVAL,
    S_PROG_OP, S_PROG_ADDR, S_PROG_DATA, S_DONE, S_ERR
  } state_e;

  state_e state, nxt;
  logic   sent, isSend;
  logic [1:0] errSet;

  assign doneO = (state == S_DONE);
  assign errO  = (state == S_ERR);

  always_comb begin
    ctl = '0; ctl.txSel = TX_DUMMY;
    nxt = state; shStart = 1'b0; dataReady = 1'b0; reqReady = 1'b0;
    isSend = 1'b0; errSet = 2'b00;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin ctl.loadReq = 1'b1; ctl.clrTimer = 1'b1; nxt = S_POLL_OP; end
      end
      S_POLL_OP: begin
        isSend = 1'b1; ctl.txSel = TX_RDSR;
        if (shDone) nxt = S_POLL_RD;
      end
      S_POLL_RD: begin
        isSend = 1'b1;
        if (shDone) begin ctl.capStatus = 1'b1; ctl.csHigh = 1'b1; nxt = S_POLL_EVAL; end
      end
      S_POLL_EVAL: begin
        if (!wip) begin
          if (remZero) nxt = S_DONE;
          else begin ctl.loadChunk = 1'b1; nxt = S_WREN; end
        end else begin
          ctl.clrGap = 1'b1; nxt = S_POLL_WAIT;
        end
      end
      S_POLL_WAIT: begin
        if (gapDone) begin
          if (tmoHit) begin errSet = 2'b01; nxt = S_ERR; end
          else nxt = S_POLL_OP;
        end
      end
      S_WREN: begin
        isSend = 1'b1; ctl.txSel = TX_WREN;
        if (shDone) begin ctl.csHigh = 1'b1; nxt = S_LAT_OP; end
      end
      S_LAT_OP: begin
        isSend = 1'b1; ctl.txSel = TX_RDSR;
        if (shDone) nxt = S_LAT_RD;
      end
      S_LAT_RD: begin
        isSend = 1'b1;
        if (shDone) begin ctl.capStatus = 1'b1; ctl.csHigh = 1'b1; nxt = S_LAT_EVAL; end
      end
      S_LAT_EVAL: begin
        if (wel) nxt = S_PROG_OP;
        else begin errSet = 2'b10; nxt = S_ERR; end
      end
      S_PROG_OP: begin
        isSend = 1'b1; ctl.txSel = TX_PROG;
        if (shDone) nxt = S_PROG_ADDR;
      end
      S_PROG_ADDR: begin
        isSend = 1'b1; ctl.txSel = TX_ADDR;
        if (shDone) begin
          ctl.addrStep = !addrLast;
          if (addrLast) nxt = S_PROG_DATA;
        end
      end
      S_PROG_DATA: begin
        isSend = 1'b1; ctl.txSel = TX_DATA;
        if (shDone && chunkEmpty) begin
          ctl.csHigh = 1'b1; ctl.clrTimer = 1'b1; nxt = S_POLL_OP;
        end
      end
      S_DONE:  nxt = S_IDLE;
      S_ERR:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (isSend && !sent && !shDone && (state != S_PROG_DATA || (dataValid && !chunkEmpty))) begin
      shStart = 1'b1; ctl.csLow = 1'b1;
      if (state == S_PROG_DATA) begin dataReady = 1'b1; ctl.dataStep = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; sent <= 1'b0; errCode <= 2'b00;
    end else begin
      state <= nxt;
      if (shDone) sent <= 1'b0;
      else if (shStart) sent <= 1'b1;
      if (ctl.loadReq) errCode <= 2'b00;
      else if (errSet != 2'b00) errCode <= errSet;
    end
  end

  AST_LATCH_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LAT_EVAL && !wel) |=> (errO && errCode == 2'b10)); // R5
  AST_BUSY_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL_WAIT && gapDone && tmoHit) |=> (errO && errCode == 2'b01)); // R4
  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneO || errO) |=> reqReady); // R9
endmodule

// File: rtl/nor_page_writer.sv
module nor_page_writer
  import nor_pw_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int MAX_WR_LOG2  = 8,
  parameter int POLL_GAP_CYC = 500,
  parameter int TIMEOUT_CYC  = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              fourByteMode,
  input  logic [3:0]        devPageLog2,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic [7:0]        dataByte,
  output logic              doneO,
  output logic              errO,
  output logic [1:0]        errCode,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  ctlStrobe_t ctl;
  logic shStart, shBusy, shDone;
  logic [7:0] txByte, rxByte;
  logic wip, wel, addrLast, chunkEmpty, remZero, gapDone, tmoHit;

  nor_pw_ctl u_ctl (
    .clk, .rstN, .reqValid, .dataValid, .shDone, .wip, .wel, .addrLast,
    .chunkEmpty, .remZero, .gapDone, .tmoHit, .ctl, .shStart, .reqReady,
    .dataReady, .doneO, .errO, .errCode
  );

  nor_pw_dp #(
    .LEN_W(LEN_W), .MAX_WR_LOG2(MAX_WR_LOG2),
    .POLL_GAP_CYC(POLL_GAP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk, .rstN, .ctl, .reqAddr, .reqLen, .fourByteMode, .devPageLog2,
    .dataByte, .rxStat(rxByte[1:0]), .txByte, .csN(spiCsN), .wip, .wel,
    .addrLast, .chunkEmpty, .remZero, .gapDone, .tmoHit
  );

  nor_pw_shift u_shift (
    .clk, .rstN, .start(shStart), .txByte, .miso(spiMiso), .busy(shBusy),
    .done(shDone), .rxByte, .sclk(spiSclk), .mosi(spiMosi)
  );

  AST_CS_FRAMES_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    shBusy |-> !spiCsN); // R6
  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> spiCsN); // R9
endmodule

// File: tb/nor_page_writer_tb.sv
module nor_page_writer_tb;
  localparam int MAXL2 = 5;
  localparam int MEMSZ = 8192;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic reqValid = 1'b0, reqReady, fourByteMode = 1'b0, dataValid = 1'b1, dataReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic [3:0]  devPageLog2 = 4'd8;
  logic [7:0]  dataByte;
  logic doneO, errO, spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;
  logic [1:0] errCode;

  nor_page_writer #(.LEN_W(16), .MAX_WR_LOG2(MAXL2), .POLL_GAP_CYC(4), .TIMEOUT_CYC(300)) u_dut (
    .clk, .rstN, .reqValid, .reqReady, .reqAddr, .reqLen, .fourByteMode, .devPageLog2,
    .dataValid, .dataReady, .dataByte, .doneO, .errO, .errCode,
    .spiSclk, .spiCsN, .spiMosi, .spiMiso
  );

  int nChk = 0, nFail = 0;
  int srcIdx = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) + 11);
  endfunction

  assign dataByte = pat(srcIdx);
  always @(posedge clk) if (dataReady && dataValid) srcIdx <= srcIdx + 1;

  // flash model, configured by the initial block only
  int  busyCfg = 0;
  bit  busyForever = 0, welBlock = 0, clrReq = 0;
  logic [7:0] mem [MEMSZ];
  logic [31:0] logAddr [64];
  int  logLen [64];
  int  ppCount = 0, rdsrCount = 0, protoErr = 0, busyLeft = 0;
  bit  welQ = 0, prevSclk = 0, prevCs = 1, outAct = 0;
  int  bitCnt = 0, byteIdx = 0, ppLen = 0;
  logic [7:0] shIn = '0, cmd = '0, outReg = '0;
  logic [31:0] ppAddr = '0;

  always @(negedge clk) begin
    if (clrReq) begin
      ppCount = 0; rdsrCount = 0; protoErr = 0; busyLeft = 0; welQ = 0;
    end
    if (prevCs && !spiCsN) begin
      bitCnt = 0; byteIdx = 0; outAct = 0; ppAddr = '0; ppLen = 0; cmd = '0;
    end
    if (!prevCs && spiCsN) begin
      if (cmd == 8'h06 && byteIdx == 1 && !welBlock) welQ = 1;
      if (cmd == 8'h02) begin
        if (!welQ || busyLeft != 0 || busyForever) protoErr++;
        if (ppCount < 64) begin logAddr[ppCount] = ppAddr; logLen[ppCount] = ppLen; end
        ppCount++; welQ = 0; busyLeft = busyCfg;
      end
      if (cmd == 8'h05 && byteIdx == 2) begin
        rdsrCount++;
        if (busyLeft > 0) busyLeft--;
      end
    end
    if (!spiCsN && spiSclk && !prevSclk) begin
      shIn = {shIn[6:0], spiMosi};
      bitCnt++;
      if (bitCnt == 8) begin
        bitCnt = 0;
        if (byteIdx == 0) begin
          cmd = shIn;
          if (shIn == 8'h05) begin
            outReg = {6'b0, welQ, (busyForever || busyLeft != 0)};
            outAct = 1;
          end
        end else if (cmd == 8'h02) begin
          if (byteIdx <= (fourByteMode ? 4 : 3)) ppAddr = {ppAddr[23:0], shIn};
          else begin
            mem[(ppAddr + 32'(ppLen)) % MEMSZ] = shIn;
            ppLen++;
          end
        end
        byteIdx++;
      end
    end
    if (!spiSclk && prevSclk && outAct) begin
      spiMiso = outReg[7];
      outReg = {outReg[6:0], 1'b0};
    end
    prevSclk = spiSclk; prevCs = spiCsN;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  // issue one request, wait for its end; returns 1 for done, 2 for error, 0 for hang
  task automatic runReq(input logic [31:0] a, input int len, input bit fb, input int pl,
                        output int result, output int base);
    @(posedge clk); clrReq = 1; @(posedge clk); clrReq = 0;
    @(negedge clk);
    base = srcIdx;
    reqAddr = a; reqLen = 16'(len); fourByteMode = fb; devPageLog2 = 4'(pl); reqValid = 1;
    @(negedge clk); reqValid = 0;
    result = 0;
    for (int c = 0; c < 40000; c++) begin
      if (doneO) begin result = 1; break; end
      if (errO)  begin result = 2; break; end
      @(negedge clk);
    end
  endtask

  // full check of a write expected to succeed
  task automatic doWrite(input logic [31:0] a, input int len, input bit fb, input int pl);
    int res, base, eff, r, k, bad, memBad, c;
    logic [31:0] ca;
    runReq(a, len, fb, pl, res, base);
    chk(res == 1 && busyLeft == 0, "R7 done with flash idle", res, 1);
    eff = 1 << ((pl < MAXL2) ? pl : MAXL2);
    ca = a; r = len; k = 0; bad = 0;
    while (r > 0) begin
      c = eff - int'(ca & 32'(eff - 1));
      if (r < c) c = r;
      if (k < 64) begin
        if (logAddr[k] != (fb ? ca : (ca & 32'h00FF_FFFF)) || logLen[k] != c) bad++;
      end
      ca += 32'(c); r -= c; k++;
    end
    chk(ppCount == k, "R1 chunk count", ppCount, k);
    chk(bad == 0, "R2/R6 chunk address and length", bad, 0);
    chk(protoErr == 0, "R3/R5 program only when idle and latched", protoErr, 0);
    memBad = 0;
    for (int i = 0; i < len; i++)
      if (mem[(a + 32'(i)) % MEMSZ] !== pat(base + i)) memBad++;
    chk(memBad == 0 && srcIdx == base + len, "R10 data order", memBad, 0);
    @(negedge clk);
    chk(reqReady && spiCsN, "R9 idle after done", {reqReady, spiCsN}, 2'b11);
  endtask

  initial begin
    int res, base, rnd;
    rnd = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(reqReady && spiCsN && !spiSclk && !doneO && !errO, "R11 reset state",
        {reqReady, spiCsN, spiSclk, doneO, errO}, 5'b11000);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && spiCsN && !spiSclk, "R11 after reset", {reqReady, spiCsN, spiSclk}, 3'b110);

    // R2: straddle a 32-byte edge
    doWrite(32'h0000_001E, 5, 0, 8);
    // R1: device page larger than write limit, then smaller
    doWrite(32'h0000_0100, 64, 0, 8);
    doWrite(32'h0000_0200, 16, 0, 3);
    // R6: four-byte address high in the map
    doWrite(32'h0300_00FC, 8, 1, 8);

    // R8: zero length
    runReq(32'h40, 0, 0, 8, res, base);
    chk(res == 1 && ppCount == 0 && rdsrCount == 1, "R8 zero length", rdsrCount, 1);

    // R3/R7: single chunk with flash busy for three reads afterwards
    busyCfg = 3;
    doWrite(32'h0000_0300, 6, 0, 8);
    chk(rdsrCount == 6, "R3 status read count", rdsrCount, 6);
    busyCfg = 0;

    // R4: busy never ends
    busyForever = 1;
    runReq(32'h400, 4, 0, 8, res, base);
    chk(res == 2 && errCode == 2'b01, "R4 timeout error", {res[1:0], errCode}, 4'b1001);
    chk(ppCount == 0, "R4 nothing programmed", ppCount, 0);
    @(negedge clk);
    chk(spiCsN && reqReady, "R9 idle after timeout", {spiCsN, reqReady}, 2'b11);
    busyForever = 0;

    // R5: latch never sets
    welBlock = 1;
    runReq(32'h500, 4, 0, 8, res, base);
    chk(res == 2 && errCode == 2'b10, "R5 latch error", {res[1:0], errCode}, 4'b1010);
    chk(ppCount == 0, "R5 nothing programmed", ppCount, 0);
    welBlock = 0;
    doWrite(32'h0000_0600, 3, 0, 8);

    // random mix
    for (int t = 0; t < 10; t++) begin
      logic [31:0] a;
      int len, pl;
      bit fb;
      a   = 32'($urandom % 4000);
      len = 1 + int'($urandom % 60);
      pl  = 2 + int'($urandom % 7);
      fb  = 1'($urandom % 2);
      if (fb) a = a | 32'h0200_0000;
      busyCfg = int'($urandom % 3);
      doWrite(a, len, fb, pl);
    end
    busyCfg = 0;
    finishRun();
  end
endmodule